// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges the level-sensitive interrupt pins of several devices into four shared interrupt lines on a root bus. Every device drives four pins. Each pin is steered onto one line by a rotation that depends on the device's slot number. A device can also sit behind a single bridge. In that case a second rotation, keyed by the bridge's own slot, carries the line onto the root bus. For each line the block keeps a count of the pins that are currently high and mapped to it, and it raises the line whenever that count is above zero.

A line is not a plain OR of pins. The block remembers the last level it saw on every pin and acts only on changes. A rising pin adds one to the count of its target line and a falling pin takes one away. When several devices change in the same cycle, the counter for each line adds up all of that cycle's rises and falls, so no event is lost. Slot numbers and the bridge assignment are meant to be configured while all of a device's pins are low, and held steady while any of them is high.

There are no states to name. The only sequential elements are the per-pin level memory and one counter per line. Each counter moves between zero and non-zero on the clock edge that follows a pin change.

Top module: `irq_line_aggregator`

## Requirements
- R1: For a device attached directly to the root bus, pin p (0 to 3, bit p of that device's 4-bit nibble in `dev_pin_lvl`) drives line (p + slot) mod 4, where only the two low bits of the 5-bit slot field count. Line k appears on bit k of `irq_line`.
- R2: For a device whose `dev_via_bridge` bit is 1, the line from R1 is rotated once more by the bridge slot: root line = ((p + slot) mod 4 + bridge_slot) mod 4.
- R3: A line is high exactly while at least one pin that maps to it is recorded as high. It falls only when the last such pin drops.
- R4: A pin that stays at the same level for any number of cycles changes no count. One fall after a long high period therefore releases the line.
- R5: Rises and falls that reach the same line in one cycle from different devices are all applied. A simultaneous rise and fall leaves the line high, and two rises followed by one fall keep it high.
- R6: A synchronous reset (`rst` high at a clock edge) clears every count and every recorded pin level, so all lines read 0. Pins held high through reset are counted again on the first edge after reset is released.
- R7: No line counter ever wraps, either below zero or above its maximum.
- R8: A pin change shows on `irq_line` after exactly one rising clock edge. The output does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_pin_lvl | input | NUM_DEV*4 | Pin levels; device d uses bits [4d+3:4d], bit 4d+p is pin p |
| dev_slot | input | NUM_DEV*SLOT_W | Slot number of each device; device d uses field d |
| dev_via_bridge | input | NUM_DEV | 1 if the device sits behind the bridge |
| bridge_slot | input | SLOT_W | Slot number of the bridge on the root bus |
| irq_line | output | 4 | Aggregated level of each shared line |

## Verification
The hardest case to reach from the ports is one where a line's count is above one, or where a fall and a rise land on the same line in the same cycle. A plain OR gate passes every test in which a single pin is high. The stimulus table therefore gives devices slots chosen so that pins of different devices collide on one line. It then lets one device hand a line to another in a single step, and raises two pins together before dropping only one. Holding pins high across a reset checks that the recorded levels are cleared along with the counts.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int PINS   = 4;
    localparam int LINES  = 4;
    localparam int LINE_W = 2;

    typedef logic [LINE_W-1:0] line_idx_t;

    // Rotation of a pin or line index by a slot number, modulo the line count.
    function automatic line_idx_t rotate_line(input line_idx_t idx, input line_idx_t slot_lo);
        return line_idx_t'(idx + slot_lo);
    endfunction

endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker
    import irq_agg_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pin_lvl,
    input  logic [SLOT_W-1:0] slot,
    input  logic              via_bridge,
    input  logic [SLOT_W-1:0] bridge_slot,
    output logic [LINES-1:0]  rise_line,
    output logic [LINES-1:0]  fall_line
);

    logic [PINS-1:0] seen_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_lvl <= '0;
        end else begin
            seen_lvl <= pin_lvl;
        end
    end

    // Each device's mapping is a permutation, so every line receives at
    // most one event per device per cycle.
    always_comb begin
        rise_line = '0;
        fall_line = '0;
        for (int p = 0; p < PINS; p++) begin
            line_idx_t ln;
            ln = rotate_line(line_idx_t'(p), slot[LINE_W-1:0]);
            if (via_bridge) begin
                ln = rotate_line(ln, bridge_slot[LINE_W-1:0]);
            end
            if (pin_lvl[p] && !seen_lvl[p]) begin
                rise_line[ln] = 1'b1;
            end
            if (!pin_lvl[p] && seen_lvl[p]) begin
                fall_line[ln] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
    parameter int NUM_DEV = 4,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DEV-1:0] rise,
    input  logic [NUM_DEV-1:0] fall,
    output logic [CNT_W-1:0]   cnt,
    output logic               active
);

    logic [CNT_W-1:0] n_up;
    logic [CNT_W-1:0] n_dn;

    always_comb begin
        n_up = '0;
        n_dn = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            n_up = n_up + CNT_W'(rise[d]);
            n_dn = n_dn + CNT_W'(fall[d]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + n_up - n_dn;
        end
    end

    assign active = (cnt != '0);

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int SLOT_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_DEV*PINS-1:0]   dev_pin_lvl,
    input  logic [NUM_DEV*SLOT_W-1:0] dev_slot,
    input  logic [NUM_DEV-1:0]        dev_via_bridge,
    input  logic [SLOT_W-1:0]         bridge_slot,
    output logic [LINES-1:0]          irq_line
);

    localparam int CNT_W = $clog2(NUM_DEV * PINS + 1);

    logic [NUM_DEV-1:0][LINES-1:0] dev_rise;
    logic [NUM_DEV-1:0][LINES-1:0] dev_fall;
    logic [LINES-1:0][NUM_DEV-1:0] line_rise;
    logic [LINES-1:0][NUM_DEV-1:0] line_fall;
    logic [LINES-1:0][CNT_W-1:0]   line_cnt;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        irq_pin_tracker #(.SLOT_W(SLOT_W)) u_trk (
            .clk        (clk),
            .rst        (rst),
            .pin_lvl    (dev_pin_lvl[d*PINS +: PINS]),
            .slot       (dev_slot[d*SLOT_W +: SLOT_W]),
            .via_bridge (dev_via_bridge[d]),
            .bridge_slot(bridge_slot),
            .rise_line  (dev_rise[d]),
            .fall_line  (dev_fall[d])
        );
        for (genvar l = 0; l < LINES; l++) begin : g_xpose
            assign line_rise[l][d] = dev_rise[d][l];
            assign line_fall[l][d] = dev_fall[d][l];
        end
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line
        irq_line_counter #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .rise  (line_rise[l]),
            .fall  (line_fall[l]),
            .cnt   (line_cnt[l]),
            .active(irq_line[l])
        );
    end

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int SLOT_W  = 5,
    parameter int CNT_W   = 5
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_DEV*PINS-1:0]   dev_pin_lvl,
    input logic [NUM_DEV*SLOT_W-1:0] dev_slot,
    input logic [NUM_DEV-1:0]        dev_via_bridge,
    input logic [SLOT_W-1:0]         bridge_slot,
    input logic [LINES-1:0]          irq_line,
    input logic [LINES-1:0][CNT_W-1:0] line_cnt
);

    // R6: a reset edge leaves every line low
    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (irq_line == '0));

    // R3: once all pins have been sampled low, no line may stay high
    a_r3_idle_lines_low: assert property (@(posedge clk) disable iff (rst)
        (dev_pin_lvl == '0) |=> (irq_line == '0));

    // R4: unchanged inputs after the first post-reset edge keep lines steady
    a_r4_hold_is_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(dev_pin_lvl) && $stable(dev_slot)
         && $stable(dev_via_bridge) && $stable(bridge_slot)) |=> $stable(irq_line));

    for (genvar l = 0; l < LINES; l++) begin : g_chk
        // R7: a counter at zero must not wrap to its maximum
        a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
            (line_cnt[l] == '0) |=> (line_cnt[l] != '1));
        // R7: a counter at its maximum must not wrap to zero
        a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
            (line_cnt[l] == '1) |=> (line_cnt[l] != '0));
    end

endmodule

bind irq_line_aggregator irq_agg_checker #(
    .NUM_DEV(NUM_DEV),
    .SLOT_W (SLOT_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dev_pin_lvl   (dev_pin_lvl),
    .dev_slot      (dev_slot),
    .dev_via_bridge(dev_via_bridge),
    .bridge_slot   (bridge_slot),
    .irq_line      (irq_line),
    .line_cnt      (line_cnt)
);

// File: tb/sim_irq_line_aggregator.sv
`timescale 1ns/1ps
module sim_irq_line_aggregator;

    localparam int ND = 4;
    localparam int SW = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [ND*4-1:0] dev_pin_lvl = '0;
    logic [ND*SW-1:0] dev_slot = '0;
    logic [ND-1:0]   dev_via_bridge = '0;
    logic [SW-1:0]   bridge_slot = '0;
    logic [3:0]      irq_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    irq_line_aggregator #(.NUM_DEV(ND), .SLOT_W(SW)) u0 (
        .clk(clk), .rst(rst), .dev_pin_lvl(dev_pin_lvl), .dev_slot(dev_slot),
        .dev_via_bridge(dev_via_bridge), .bridge_slot(bridge_slot), .irq_line(irq_line)
    );

    always #2.5 clk = ~clk;

    // Rows: {pins d3..d0 (16 bits), expected lines (4 bits)}; slots are 0,1,2,3.
    localparam logic [19:0] VEC [10] = '{
        {16'h0000, 4'h0},
        {16'h0001, 4'h1},
        {16'h0081, 4'h1},
        {16'h0080, 4'h1},
        {16'h0200, 4'h8},
        {16'h3200, 4'h9},
        {16'h000F, 4'hF},
        {16'h1111, 4'hF},
        {16'h1110, 4'hE},
        {16'h0000, 4'h0}
    };

    task automatic check(input string req, input logic [3:0] exp);
        n_cmp++;
        if (irq_line !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_line=%h expected=%h at %0t", req, irq_line, exp, $time);
        end
    endtask

    task automatic set_pins(input logic [15:0] p);
        @(negedge clk);
        dev_pin_lvl = p;
    endtask

    task automatic step_check(input logic [15:0] p, input logic [3:0] exp, input string req);
        set_pins(p);
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [3:0] prev_exp;
        dev_slot = {5'd3, 5'd2, 5'd1, 5'd0};
        repeat (3) @(negedge clk);
        check("R6 reset state", 4'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 idle after reset", 4'h0);

        // Table walk: R1 rotation, R3 sharing, R5 collisions, R8 latency
        prev_exp = 4'h0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            dev_pin_lvl = VEC[i][19:4];
            #1;
            check("R8 no change before edge", prev_exp);
            @(negedge clk);
            check("R1/R3/R5 table row", VEC[i][3:0]);
            prev_exp = VEC[i][3:0];
        end

        // R4: long hold then single fall
        set_pins(16'h0001);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R4 held high", 4'h1);
        end
        step_check(16'h0000, 4'h0, "R4 single fall releases");

        // R5: handover in one cycle, and two rises then one fall
        step_check(16'h0001, 4'h1, "R5 first owner");
        step_check(16'h0080, 4'h1, "R5 rise+fall same cycle");
        step_check(16'h0000, 4'h0, "R5 last drop");
        step_check(16'h0081, 4'h1, "R5 double rise");
        step_check(16'h0001, 4'h1, "R5 one of two falls");
        step_check(16'h0000, 4'h0, "R5 both fallen");

        // R1: only low slot bits matter (slot 5 acts as 1)
        @(negedge clk);
        dev_slot = {5'd3, 5'd2, 5'd1, 5'd5};
        step_check(16'h0001, 4'h2, "R1 slot high bits ignored");
        step_check(16'h0000, 4'h0, "R1 release");

        // R2: bridge rotation with bridge slot 2
        @(negedge clk);
        dev_slot = {5'd3, 5'd2, 5'd1, 5'd0};
        dev_via_bridge = 4'b1010;
        bridge_slot = 5'd2;
        step_check(16'h0080, 4'h4, "R2 bridged dev1 pin3");
        step_check(16'h1080, 4'h6, "R2 bridged dev3 pin0 added");
        step_check(16'h1081, 4'h7, "R2 direct dev0 alongside bridged");
        step_check(16'h0000, 4'h0, "R2 release");
        @(negedge clk);
        dev_via_bridge = '0;
        bridge_slot = '0;

        // R6: pins held high across reset
        step_check(16'h000F, 4'hF, "R6 pre-reset level");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R6 reset clears lines", 4'h0);
        @(negedge clk);
        check("R6 still in reset", 4'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 held pins recounted", 4'hF);
        step_check(16'h0000, 4'h0, "R7 falls to zero without wrap");

        done = 1;
        finish_run();
    end

endmodule